// File: doc/BRIEF.md
# Register-Mapped Serial Port

This block is a single-channel asynchronous serial port that sits on the register file of a small 8-bit controller. The transmit and receive hold registers share one register address. A write to that address queues a byte for transmission. A read from that address returns the most recently received byte. The frame is one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity.

All timing comes from the processor clock. A fixed divider produces a tick at sixteen times the baud rate, and both directions share that tick. The divider parameter is (clock / (16 × baud)) − 1. For a 14.7456 MHz clock and 115200 baud this gives 7. The hold address is also a parameter, so the port can be moved off an address that another peripheral needs.

Each direction has its own flags. The transmitter reports that it is busy. The receiver reports when data is valid, and it flags an overrun and a framing error. The block works with its serial output wired back to its serial input.

Top module: `regfile_uart`

## Requirements
- R1: While reset is held and right after it, `txd` is high and `tx_busy`, `rx_valid`, `rx_overrun` and `rx_frame_err` are all low.
- R2: A write with `reg_we` high at address `HOLD_ADDR` sends one frame on `txd`. The frame is a low start bit, then the eight data bits least significant bit first, then a high stop bit. Each bit lasts 16 × (DIV+1) clocks.
- R3: A write to any address other than `HOLD_ADDR` is ignored: `tx_busy` stays low and `txd` stays high. A read of any other address returns 0 and leaves `rx_valid` unchanged.
- R4: With `txd` looped back to `rxd`, each byte sent is received. `rx_valid` goes high, and a read at `HOLD_ADDR` returns the byte on `reg_rdata`.
- R5: A read with `reg_re` high at `HOLD_ADDR` clears `rx_valid`, `rx_overrun` and `rx_frame_err` after that clock edge.
- R6: The receiver starts a frame on a falling edge of `rxd`. If the line is high again at mid start bit (8 ticks later), the start is dropped: no byte is stored and no flag is set.
- R7: If the stop bit is sampled low, `rx_frame_err` is set, and both the receive hold register and `rx_valid` keep their previous values.
- R8: If a byte completes while `rx_valid` is still set, `rx_overrun` is set and the hold register takes the new byte.
- R9: `tx_busy` is high while a byte is either waiting in the hold register or being shifted out. A write made while busy is sent immediately after the current frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | ADDR_W | Register file address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Receive hold register when the address matches, else 0 |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input |
| tx_busy | output | 1 | Transmit hold register full or shifter active |
| rx_valid | output | 1 | Unread received byte present |
| rx_overrun | output | 1 | A byte arrived while the previous one was unread |
| rx_frame_err | output | 1 | Last frame had a low stop bit |

## Verification
The bench builds the block with DIV = 1, so one bit lasts 32 clocks and dozens of full frames fit in a short run. It also sets HOLD_ADDR = 5. This shows that the hold address really moves and lets the default address 7 serve as the ignored address. With these values the bench can reach, within a few hundred cycles each, the back-to-back frames, overruns, framing errors and runt start pulses it drives by hand.

// File: rtl/regfile_uart.sv
module regfile_uart #(
  parameter int ADDR_W    = 5,
  parameter int HOLD_ADDR = 7,
  parameter int DIV       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [7:0]        reg_rdata,
  output logic              txd,
  input  logic              rxd,
  output logic              tx_busy,
  output logic              rx_valid,
  output logic              rx_overrun,
  output logic              rx_frame_err
);
  localparam int DW = (DIV < 1) ? 1 : $clog2(DIV + 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;

  logic [DW-1:0] div_cnt;
  wire tick = (div_cnt == DW'(DIV));
  wire hit  = (reg_addr == ADDR_W'(HOLD_ADDR));
  wire wr   = reg_we & hit;
  wire rd   = reg_re & hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + 1'b1;

  logic [7:0] thr;
  logic       thr_full, tx_active;
  logic [9:0] tx_sh;
  logic [3:0] tx_os, tx_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr <= '0; thr_full <= 1'b0; tx_active <= 1'b0;
      tx_sh <= '1; tx_os <= '0; tx_cnt <= '0;
    end else begin
      if (!tx_active && thr_full) begin
        tx_sh     <= {1'b1, thr, 1'b0};
        tx_active <= 1'b1;
        tx_os     <= '0;
        tx_cnt    <= '0;
        thr_full  <= 1'b0;
      end else if (tx_active && tick) begin
        tx_os <= tx_os + 1'b1;
        if (tx_os == 4'd15) begin
          tx_sh  <= {1'b1, tx_sh[9:1]};
          tx_cnt <= tx_cnt + 1'b1;
          if (tx_cnt == 4'd9) tx_active <= 1'b0;
        end
      end
      if (wr) begin
        thr      <= reg_wdata;
        thr_full <= 1'b1;
      end
    end
  end

  assign txd     = tx_active ? tx_sh[0] : 1'b1;
  assign tx_busy = tx_active | thr_full;

  logic       rx_meta, rx_s, rx_prev;
  rx_st_t     rx_st;
  logic [3:0] rx_os;
  logic [2:0] rx_cnt;
  logic [7:0] rx_sh, rx_hold;

  wire rx_mid   = tick && (rx_os == 4'd15);
  wire stop_bad = (rx_st == RX_STOP) && rx_mid && !rx_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rx_meta, rx_s, rx_prev} <= 3'b111;
    else        {rx_meta, rx_s, rx_prev} <= {rxd, rx_meta, rx_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st <= RX_IDLE; rx_os <= '0; rx_cnt <= '0; rx_sh <= '0; rx_hold <= '0;
      rx_valid <= 1'b0; rx_overrun <= 1'b0; rx_frame_err <= 1'b0;
    end else begin
      if (rd) begin
        rx_valid <= 1'b0; rx_overrun <= 1'b0; rx_frame_err <= 1'b0;
      end
      case (rx_st)
        RX_IDLE:
          if (rx_prev && !rx_s) begin rx_st <= RX_START; rx_os <= '0; end
        RX_START:
          if (tick) begin
            rx_os <= rx_os + 1'b1;
            if (rx_os == 4'd7) begin
              rx_os  <= '0;
              rx_cnt <= '0;
              rx_st  <= rx_s ? RX_IDLE : RX_DATA;
            end
          end
        RX_DATA:
          if (tick) begin
            rx_os <= rx_os + 1'b1;
            if (rx_mid) begin
              rx_sh  <= {rx_s, rx_sh[7:1]};
              rx_cnt <= rx_cnt + 1'b1;
              if (rx_cnt == 3'd7) rx_st <= RX_STOP;
            end
          end
        RX_STOP:
          if (tick) begin
            rx_os <= rx_os + 1'b1;
            if (rx_mid) begin
              rx_st <= RX_IDLE;
              if (rx_s) begin
                rx_hold  <= rx_sh;
                rx_valid <= 1'b1;
                if (rx_valid) rx_overrun <= 1'b1;
              end else begin
                rx_frame_err <= 1'b1;
              end
            end
          end
        default: rx_st <= RX_IDLE;
      endcase
    end
  end

  assign reg_rdata = hit ? rx_hold : 8'h00;

  AST_WR_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> tx_busy); // R9
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> !txd); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !((rx_st == RX_STOP) && rx_mid)) |=> !rx_valid); // R5
  AST_FERR_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stop_bad |=> ($stable(rx_hold) && rx_frame_err)); // R7
  AST_OVR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(rx_valid)); // R8
  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_st == RX_START) && tick && (rx_os == 4'd7) && rx_s) |=> (rx_st == RX_IDLE)); // R6
endmodule

// File: tb/regfile_uart_test.sv
module regfile_uart_test;
  localparam int DIV = 1;
  localparam int HA  = 5;
  localparam int BP  = 16 * (DIV + 1);

  logic clk = 0, rst_n = 0;
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic reg_we = 0, reg_re = 0;
  logic txd, tx_busy, rx_valid, rx_overrun, rx_frame_err;
  logic loop = 1, drv = 1;
  wire  rxd = loop ? txd : drv;
  int checks = 0, fails = 0;

  regfile_uart #(.ADDR_W(5), .HOLD_ADDR(HA), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .txd(txd), .rxd(rxd),
    .tx_busy(tx_busy), .rx_valid(rx_valid), .rx_overrun(rx_overrun),
    .rx_frame_err(rx_frame_err));

  always #5 clk = ~clk;

  localparam logic [7:0] VEC [6] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h81, 8'h3C};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1; #1 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 2000 && !rx_valid; i++) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); drv = f[i];
      repeat (BP - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [9:0] got;
    repeat (5) @(negedge clk);
    check("R1 txd", txd, 1);
    check("R1 flags", {tx_busy, rx_valid, rx_overrun, rx_frame_err}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {txd, tx_busy, rx_valid, rx_overrun, rx_frame_err}, 5'b10000);

    // R3: the default address 7 is not the hold address in this build
    wr_reg(7, 8'hC5);
    repeat (3) @(negedge clk);
    check("R3 busy", tx_busy, 0);
    check("R3 txd", txd, 1);
    repeat (400) @(negedge clk);
    check("R3 no rx", rx_valid, 0);

    // R2 bit timing and order
    wr_reg(HA, 8'hB2);
    for (int i = 0; i < 100 && txd; i++) @(negedge clk);
    repeat (BP / 2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      got[i] = txd;
      if (i < 9) repeat (BP) @(negedge clk);
    end
    check("R2 frame", got, {1'b1, 8'hB2, 1'b0});
    wait_valid();
    check("R4 valid", rx_valid, 1);
    rd_reg(7, d);
    check("R3 other read data", d, 0);
    check("R3 other read keeps valid", rx_valid, 1);
    rd_reg(HA, d);
    check("R4 data", d, 8'hB2);
    check("R5 valid cleared", rx_valid, 0);

    for (int k = 0; k < 6; k++) begin
      wr_reg(HA, VEC[k]);
      wait_valid();
      check("R4 loop valid", rx_valid, 1);
      rd_reg(HA, d);
      check("R4 loop data", d, VEC[k]);
      check("R5 loop clear", rx_valid, 0);
    end

    // R6 runt start pulse
    loop = 0; drv = 1;
    repeat (10) @(negedge clk);
    drv = 0; repeat (6) @(negedge clk); drv = 1;
    repeat (400) @(negedge clk);
    check("R6 no byte", {rx_valid, rx_frame_err, rx_overrun}, 0);
    send_frame(8'h6E, 1'b1);
    drv = 1;
    wait_valid();
    rd_reg(HA, d);
    check("R6 recovers", d, 8'h6E);

    // R7 low stop bit
    send_frame(8'h19, 1'b0);
    drv = 1;
    repeat (BP) @(negedge clk);
    check("R7 ferr", rx_frame_err, 1);
    check("R7 valid kept", rx_valid, 0);
    rd_reg(HA, d);
    check("R7 hold kept", d, 8'h6E);
    check("R5 ferr cleared", rx_frame_err, 0);

    // R8 overrun
    loop = 1;
    repeat (BP) @(negedge clk);
    wr_reg(HA, 8'h11);
    wait_valid();
    wr_reg(HA, 8'h22);
    for (int i = 0; i < 2000 && tx_busy; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R8 overrun", rx_overrun, 1);
    rd_reg(HA, d);
    check("R8 new byte", d, 8'h22);
    check("R5 overrun cleared", {rx_overrun, rx_valid}, 0);

    // R9 queued write while busy
    wr_reg(HA, 8'h4D);
    wr_reg(HA, 8'hE7);
    check("R9 busy", tx_busy, 1);
    wait_valid();
    rd_reg(HA, d);
    check("R9 first", d, 8'h4D);
    wait_valid();
    rd_reg(HA, d);
    check("R9 second", d, 8'hE7);
    check("R9 no overrun", rx_overrun, 0);
    repeat (BP) @(negedge clk);
    check("R9 idle", {tx_busy, txd}, 2'b01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule